// File: doc/BRIEF.md
# Two-of-Three Ones Majority Detector

This block watches a single serial bit stream and raises a registered flag whenever at least two of the three most recently accepted bits are 1. A bit is accepted only on a rising clock edge where the valid strobe is high. On all other edges the detector holds everything it has, so a sparse or bursty producer can feed it without any gating of its own.

The detector is built as an explicit seven-state machine held in a three-bit binary register. Three start-up states cover the period before two bits have arrived: one for nothing received yet, and one for each value of a lone first bit. Four steady states then record the two most recent bits. Once the machine is in a steady state it stays among the steady states until the next reset. The eighth register code is never entered in normal operation. If the register is ever found holding that code, the next edge returns the machine to the empty state.

The flag is computed from the stored state together with the incoming bit, and it is registered on the same edge that accepts the bit. The verdict for a bit therefore appears one cycle after that bit is presented. When fewer than three bits have arrived, the verdict is taken over the bits that are available.

Top module: `maj3_det`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, each rising edge puts the machine in its empty state and drives `hit_o` to 0, whatever the data inputs are.
- R2: The first bit accepted after reset always yields `hit_o` = 0, whatever its value.
- R3: The second bit accepted after reset yields `hit_o` = 1 only if both accepted bits are 1, and 0 otherwise.
- R4: From the third accepted bit onward, `hit_o` is 1 exactly when two or more of the last three accepted bits are 1.
- R5: On an edge where `din_vld` is low, `hit_o` and the machine state are unchanged, whatever the value of `din_bit`.
- R6: Once two bits have been accepted, the machine never returns to a start-up state except through reset. A later stream is always judged over a full three-bit window.
- R7: If the state register holds the unused code 3'b111, the next edge moves it to the empty state (3'b000) and drives `hit_o` to 0, whatever `din_vld` is.
- R8: `hit_o` changes only on the rising edge that accepts a bit. Presenting a bit does not change the output before that edge.
- R9: After reset, the accepted stream 0,1,1,0,1,1,1,0,0 gives the per-bit outputs 0,0,1,1,1,1,1,1,0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din_bit | input | 1 | Serial data bit |
| din_vld | input | 1 | High on edges where `din_bit` is accepted |
| hit_o | output | 1 | Registered verdict: two or more ones among the last three accepted bits |

## Verification
The bound checker examines every edge. It checks that the reset state is entered, and that the output holds on edges with no valid bit. It checks the start-up verdicts for the first and second bits and the steady-state vote against the previous state and bit. It checks that the machine never falls back from a steady state to a start-up state, and that the unused code recovers. The bench scenarios show what the checker cannot: the full worked stream, every three-bit window, the output staying put before the accepting edge, long bursty streams against an independent window model, and the recovery from an injected unused code as seen at the output.

// File: rtl/maj3_pkg.sv
package maj3_pkg;

    localparam int ST_W = 3;

    // 3'b111 is never entered in normal operation
    typedef enum logic [ST_W-1:0] {
        ST_EMPTY = 3'd0,
        ST_ONE0  = 3'd1,
        ST_ONE1  = 3'd2,
        ST_W00   = 3'd3,
        ST_W01   = 3'd4,
        ST_W10   = 3'd5,
        ST_W11   = 3'd6,
        ST_BAD   = 3'd7
    } state_e;

    typedef struct packed {
        state_e state;
        logic   hit;
    } regs_t;

endpackage

// File: rtl/maj3_next.sv
module maj3_next
    import maj3_pkg::*;
(
    input  state_e cur,
    input  logic   bit_i,
    input  logic   vld_i,
    output state_e nxt
);
    // steady state keyed on {older, newer} bits
    function automatic state_e pair_state(input logic older, input logic newer);
        case ({older, newer})
            2'b00:   return ST_W00;
            2'b01:   return ST_W01;
            2'b10:   return ST_W10;
            default: return ST_W11;
        endcase
    endfunction

    always_comb begin
        nxt = cur;
        if (cur == ST_BAD) begin
            nxt = ST_EMPTY;
        end else if (vld_i) begin
            case (cur)
                ST_EMPTY: nxt = bit_i ? ST_ONE1 : ST_ONE0;
                ST_ONE0,
                ST_W00,
                ST_W10:   nxt = pair_state(1'b0, bit_i);
                ST_ONE1,
                ST_W01,
                ST_W11:   nxt = pair_state(1'b1, bit_i);
                default:  nxt = ST_EMPTY;
            endcase
        end
    end

endmodule

// File: rtl/maj3_vote.sv
module maj3_vote
    import maj3_pkg::*;
(
    input  state_e cur,
    input  logic   bit_i,
    output logic   vote
);
    always_comb begin
        case (cur)
            ST_ONE1,
            ST_W01,
            ST_W10:  vote = bit_i;
            ST_W11:  vote = 1'b1;
            default: vote = 1'b0;
        endcase
    end

endmodule

// File: rtl/maj3_det.sv
module maj3_det
    import maj3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din_bit,
    input  logic din_vld,
    output logic hit_o
);
    state_e state_q;
    logic   hit_q;
    state_e state_nx;
    logic   vote;
    regs_t  r_d;

    maj3_next u_next (
        .cur   (state_q),
        .bit_i (din_bit),
        .vld_i (din_vld),
        .nxt   (state_nx)
    );

    maj3_vote u_vote (
        .cur   (state_q),
        .bit_i (din_bit),
        .vote  (vote)
    );

    always_comb begin
        r_d.state = state_nx;
        r_d.hit   = hit_q;
        if (state_q == ST_BAD) begin
            r_d.hit = 1'b0;
        end else if (din_vld) begin
            r_d.hit = vote;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            hit_q   <= 1'b0;
        end else begin
            state_q <= r_d.state;
            hit_q   <= r_d.hit;
        end
    end

    assign hit_o = hit_q;

endmodule

// File: rtl/maj3_det_chk.sv
module maj3_det_chk
    import maj3_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   din_bit,
    input logic   din_vld,
    input logic   hit_o,
    input state_e state_q
);
    logic steady;
    assign steady = (state_q == ST_W00) || (state_q == ST_W01) ||
                    (state_q == ST_W10) || (state_q == ST_W11);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (state_q == ST_EMPTY) && !hit_o);

    p_first_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY && din_vld) |=> !hit_o);

    p_second_one_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ONE1 && din_vld && din_bit) |=> hit_o);

    p_second_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ONE0 && din_vld) || (state_q == ST_ONE1 && din_vld && !din_bit))
        |=> !hit_o);

    p_vote_r4: assert property (@(posedge clk) disable iff (rst)
        (steady && din_vld) |=>
        hit_o == (($past(state_q) == ST_W11) ||
                  ((($past(state_q) == ST_W01) || ($past(state_q) == ST_W10)) && $past(din_bit))));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!din_vld && state_q != ST_BAD) |=> $stable(hit_o));

    p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
        steady |=> !((state_q == ST_EMPTY) || (state_q == ST_ONE0) || (state_q == ST_ONE1)));

    p_unused_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BAD) |=> (state_q == ST_EMPTY) && !hit_o);

endmodule

bind maj3_det maj3_det_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .din_bit (din_bit),
    .din_vld (din_vld),
    .hit_o   (hit_o),
    .state_q (state_q)
);

// File: tb/maj3_det_tb.sv
`timescale 1ns/1ps
module maj3_det_tb;
    import maj3_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din_bit = 1'b0;
    logic din_vld = 1'b0;
    logic hit_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int       m_cnt;
    logic [2:0] m_hist;
    logic     m_exp;

    maj3_det u_dut (
        .clk     (clk),
        .rst     (rst),
        .din_bit (din_bit),
        .din_vld (din_vld),
        .hit_o   (hit_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic model_clear();
        m_cnt  = 0;
        m_hist = 3'b000;
        m_exp  = 1'b0;
    endtask

    task automatic model_push(input logic b);
        m_hist = {m_hist[1:0], b};
        if (m_cnt < 3) m_cnt++;
        case (m_cnt)
            1:       m_exp = 1'b0;
            2:       m_exp = m_hist[1] & m_hist[0];
            default: m_exp = ($countones(m_hist) >= 2);
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din_vld = 1'b1;
        din_bit = 1'b1;
        repeat (3) @(negedge clk);
        chk(hit_o, 1'b0, "R1 output low under reset");
        rst = 1'b0;
        din_vld = 1'b0;
        model_clear();
    endtask

    // present a bit, confirm no early change, then check after the edge
    task automatic send(input logic b, input string req);
        @(negedge clk);
        din_bit = b;
        din_vld = 1'b1;
        #1;
        chk(hit_o, m_exp, "R8 output unchanged before accepting edge");
        model_push(b);
        @(posedge clk);
        #1;
        chk(hit_o, m_exp, req);
        din_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din_vld = 1'b0;
            din_bit = ~din_bit;
            @(posedge clk);
            #1;
            chk(hit_o, m_exp, "R5 hold with valid low");
        end
    endtask

    task automatic t_worked();
        logic [8:0] ins  = 9'b011011100;
        logic [8:0] outs = 9'b001111110;
        do_reset();
        for (int i = 8; i >= 0; i--) begin
            send(ins[i], "R9 worked stream (model)");
            chk(hit_o, outs[i], "R9 worked stream (listed)");
        end
    endtask

    task automatic t_startup();
        for (int p = 0; p < 4; p++) begin
            do_reset();
            send(p[1], "R2 first bit gives zero");
            send(p[0], "R3 second bit verdict");
            chk(hit_o, p[1] & p[0], "R3 second bit listed");
        end
    endtask

    task automatic t_windows();
        do_reset();
        send(1'b0, "R2 prefix");
        send(1'b0, "R3 prefix");
        for (int w = 0; w < 8; w++) begin
            for (int k = 2; k >= 0; k--) begin
                send(w[k], "R4 three-bit window");
            end
        end
    endtask

    task automatic t_hold();
        do_reset();
        send(1'b1, "R2 before gaps");
        idle(3);
        send(1'b1, "R3 after gap");
        idle(4);
        send(1'b0, "R4 after gap");
        idle(2);
        send(1'b0, "R4 after gap");
        idle(2);
        send(1'b1, "R4 after gap");
    endtask

    task automatic t_long();
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3] | lfsr[7]) send(lfsr[0], "R6 long stream stays windowed");
            else idle(1);
        end
    endtask

    task automatic t_unused();
        do_reset();
        send(1'b1, "R2 setup");
        send(1'b1, "R3 setup");
        send(1'b1, "R4 setup");
        @(negedge clk);
        din_vld = 1'b0;
        force u_dut.state_q = ST_BAD;
        #1;
        release u_dut.state_q;
        @(posedge clk);
        #1;
        chk(hit_o, 1'b0, "R7 unused code clears output");
        model_clear();
        send(1'b0, "R7 recovered to empty (first bit)");
        send(1'b1, "R7 recovered to empty (second bit)");
    endtask

    initial begin
        model_clear();
        do_reset();
        t_worked();
        t_startup();
        t_windows();
        t_hold();
        t_long();
        t_unused();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule